// File: doc/BRIEF.md
# Bus-Attached Arithmetic Unit with Private Operand Registers

This block is an arithmetic and logic unit that hangs off a shared data bus. Two private operand registers, called left and right here, each take a word from the bus on a clock edge when their own load strobe is high. Operands are captured one bus beat at a time. Each register's output runs straight into the arithmetic core and never travels back over the bus.

The core works continuously. It adds, subtracts, ANDs, ORs or XORs the two held operands, as chosen by a three-bit operation code. Subtraction goes through the same adder as addition: the right operand is inverted and the carry-in is forced to one. The carry output then reads one when no borrow occurred.

The result reaches the bus only while the output-enable is high. When the enable is low the result port is released. Released means it carries all zeros and the drive-valid flag is low, so a wired-OR bus merge takes nothing from this unit and a contention monitor can count how many drivers are active.

Top module: `bus_alu`

## Requirements
- R1: A synchronous active-low reset clears both operand registers to zero. After reset, with the enable high and the ADD code selected, the result reads 0 and the carry reads 0.
- R2: When `ld_left` is high at a rising clock edge, the left operand register takes `bus_in`. Otherwise it keeps its value.
- R3: When `ld_right` is high at a rising clock edge, the right operand register takes `bus_in`. Otherwise it keeps its value. This happens independently of the left register.
- R4: Code 3'b000 (ADD) gives (left + right) mod 2^W on the result. The carry is the bit above the top result bit.
- R5: Code 3'b001 (SUB) gives (left - right) mod 2^W. The carry is 1 exactly when left >= right, meaning no borrow.
- R6: Code 3'b010 gives AND, 3'b011 gives OR and 3'b100 gives XOR, each bitwise on the operands, with the carry at 0.
- R7: Codes 3'b101, 3'b110 and 3'b111 give a result of zero and a carry of 0.
- R8: While `res_oe` is low, `bus_out` is all zeros and `drv_valid` is 0. While `res_oe` is high, `drv_valid` is 1 and `bus_out` carries the result.
- R9: A change on `bus_in` with both load strobes low leaves the result unchanged, because operands never pass through the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_in | input | W | Word currently on the shared bus |
| ld_left | input | 1 | Capture the bus into the left operand |
| ld_right | input | 1 | Capture the bus into the right operand |
| op_code | input | 3 | Operation select |
| res_oe | input | 1 | Drive the result onto the bus |
| bus_out | output | W | Result when driving, zeros when released |
| drv_valid | output | 1 | High while this unit drives the bus |
| carry | output | 1 | Adder carry-out, or no-borrow flag on SUB |

## Verification
The hardest case to reach is a result formed from two distinct operands. The ports offer only one bus word per beat, so the two operands can never be presented together. The stimulus therefore loads left and right in two separate beats, holding the other strobe low each time. It then steps through all eight operation codes while the registers stay still. The bench runs a 4-bit instance and covers every operand pair this way, so the borrow boundary left == right and the wrap at the top of the adder are hit exhaustively. Released-output and bus-isolation checks are placed between these load beats.

// File: rtl/bus_alu_pkg.sv
// Package: shared operation codes for the bus arithmetic unit.
// Assumes a three-bit operation field; codes above XOR are unused.
package bus_alu_pkg;

    typedef enum logic [2:0] {
        OPC_ADD = 3'b000,
        OPC_SUB = 3'b001,
        OPC_AND = 3'b010,
        OPC_OR  = 3'b011,
        OPC_XOR = 3'b100
    } opc_t;

    localparam int OPC_BITS = 3;

    // True when the code names a bitwise operation.
    function automatic logic is_logic_op(input logic [OPC_BITS-1:0] c);
        return (c == OPC_AND) || (c == OPC_OR) || (c == OPC_XOR);
    endfunction

endpackage

// File: rtl/bus_alu_opreg.sv
// Operand register: captures the bus word on a clock edge when its load
// strobe is high and holds it otherwise. Assumes a synchronous active-low
// reset that clears it to zero.
module bus_alu_opreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Purpose: capture on load, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

    // R2 / R3: a capture lands the word present at the edge.
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));

    // R2 / R3: with no strobe the held word does not move.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(rst_n)) |=> $stable(q));

endmodule

// File: rtl/bus_alu_core.sv
// Arithmetic core: one adder serves ADD and SUB (right operand inverted
// with carry-in one on SUB); bitwise ops bypass it. Purely combinational.
// Assumes unused codes must yield zero result and zero carry.
module bus_alu_core
    import bus_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]        lhs,
    input  logic [W-1:0]        rhs,
    input  logic [OPC_BITS-1:0] opc,
    output logic [W-1:0]        res,
    output logic                cout
);

    localparam int SW = W + 1;

    logic            do_sub;
    logic [W-1:0]    rhs_eff;
    logic [SW-1:0]   sum_ext;

    // Purpose: condition the right operand and carry-in for the shared adder.
    always_comb begin
        do_sub  = (opc == OPC_SUB);
        rhs_eff = do_sub ? ~rhs : rhs;
    end

    // Purpose: the single shared adder with its carry-out bit.
    always_comb begin
        sum_ext = {1'b0, lhs} + {1'b0, rhs_eff} + {{W{1'b0}}, do_sub};
    end

    // Purpose: pick the result and carry for the selected operation.
    always_comb begin
        res  = '0;
        cout = 1'b0;
        case (opc)
            OPC_ADD, OPC_SUB: begin
                res  = sum_ext[W-1:0];
                cout = sum_ext[W];
            end
            OPC_AND: res = lhs & rhs;
            OPC_OR:  res = lhs | rhs;
            OPC_XOR: res = lhs ^ rhs;
            default: begin
                res  = '0;
                cout = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bus_alu_driver.sv
// Bus driver: passes the result while enabled and releases the port
// (all zeros, valid low) otherwise, suited to a wired-OR bus merge.
// Assumes the enable is held for the whole beat by the bus controller.
module bus_alu_driver #(
    parameter int W = 8
) (
    input  logic         oe,
    input  logic [W-1:0] res,
    output logic [W-1:0] bus_q,
    output logic         valid
);

    // Purpose: gate every result bit by the output enable.
    for (genvar i = 0; i < W; i++) begin : g_gate
        assign bus_q[i] = res[i] & oe;
    end

    // Purpose: advertise that this unit is a driver this beat.
    assign valid = oe;

endmodule

// File: rtl/bus_alu.sv
// Top: two private operand registers loaded from the bus, a shared-adder
// arithmetic core fed straight from them, and a gated result driver.
// Assumes one bus word per beat, so operands arrive in separate beats.
module bus_alu
    import bus_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0]        bus_in,
    input  logic                ld_left,
    input  logic                ld_right,
    input  logic [OPC_BITS-1:0] op_code,
    input  logic                res_oe,
    output logic [W-1:0]        bus_out,
    output logic                drv_valid,
    output logic                carry
);

    localparam int NOPS = 2;

    logic [NOPS-1:0]        ld_vec;
    logic [NOPS-1:0][W-1:0] opnd;
    logic [W-1:0]           core_res;

    // Purpose: collect the per-operand load strobes (0 = left, 1 = right).
    assign ld_vec = {ld_right, ld_left};

    // Purpose: one capture register per operand.
    for (genvar k = 0; k < NOPS; k++) begin : g_opnd
        bus_alu_opreg #(.W(W)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (ld_vec[k]),
            .d     (bus_in),
            .q     (opnd[k])
        );
    end

    bus_alu_core #(.W(W)) u_core (
        .lhs  (opnd[0]),
        .rhs  (opnd[1]),
        .opc  (op_code),
        .res  (core_res),
        .cout (carry)
    );

    bus_alu_driver #(.W(W)) u_drv (
        .oe    (res_oe),
        .res   (core_res),
        .bus_q (bus_out),
        .valid (drv_valid)
    );

    // R5: SUB carry tracks the unsigned ordering of the held operands.
    p_no_borrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OPC_SUB) |-> (carry == (opnd[0] >= opnd[1])));

    // R6: bitwise operations never raise the carry.
    p_logic_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_logic_op(op_code) |-> !carry);

    // R7: unused codes give zero on the core and no carry.
    p_unused_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code > OPC_XOR) |-> (core_res == '0 && !carry));

    // R8: a released port contributes nothing to the bus.
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_oe |-> (bus_out == '0 && !drv_valid));

    // R8: while enabled the bus sees the core result and a valid driver.
    p_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_oe |-> (drv_valid && bus_out == core_res));

    // R1: the cycle after reset both operands read zero.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (opnd[0] == '0 && opnd[1] == '0));

endmodule

// File: tb/sim_bus_alu.sv
`timescale 1ns/100ps
module sim_bus_alu;

    localparam int W    = 4;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] bus_in = '0;
    logic         ld_left = 1'b0;
    logic         ld_right = 1'b0;
    logic [2:0]   op_code = 3'b000;
    logic         res_oe = 1'b0;
    logic [W-1:0] bus_out;
    logic         drv_valid;
    logic         carry;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    bus_alu #(.W(W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_in    (bus_in),
        .ld_left   (ld_left),
        .ld_right  (ld_right),
        .op_code   (op_code),
        .res_oe    (res_oe),
        .bus_out   (bus_out),
        .drv_valid (drv_valid),
        .carry     (carry)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic load_word(input bit right, input int val);
        @(negedge clk);
        bus_in = val[W-1:0];
        ld_left  = !right;
        ld_right = right;
        @(negedge clk);
        ld_left  = 1'b0;
        ld_right = 1'b0;
    endtask

    function automatic int exp_res(input int op, input int a, input int b);
        case (op)
            0: return (a + b) & MASK;
            1: return (a - b) & MASK;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_cy(input int op, input int a, input int b);
        case (op)
            0: return ((a + b) >> W) & 1;
            1: return (a >= b) ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    function automatic string op_tag(input int op);
        case (op)
            0: return "R4 add";
            1: return "R5 sub";
            2, 3, 4: return "R6 logic";
            default: return "R7 unused";
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        res_oe = 1'b1;
        op_code = 3'b000;
        #1;
        check("R1 reset result", int'(bus_out), 0);
        check("R1 reset carry", int'(carry), 0);

        for (int a = 0; a <= MASK; a++) begin
            for (int b = 0; b <= MASK; b++) begin
                load_word(1'b0, a);   // R2 left capture
                load_word(1'b1, b);   // R3 right capture
                res_oe = 1'b1;
                for (int op = 0; op < 8; op++) begin
                    op_code = op[2:0];
                    #1;
                    check(op_tag(op), int'(bus_out), exp_res(op, a, b));
                    check({op_tag(op), " carry"}, int'(carry), exp_cy(op, a, b));
                end
                // R8: released port shows zeros and no drive
                res_oe = 1'b0;
                op_code = 3'b011;
                #1;
                check("R8 released bus", int'(bus_out), 0);
                check("R8 released valid", int'(drv_valid), 0);
                res_oe = 1'b1;
                #1;
                check("R8 driving valid", int'(drv_valid), 1);
                // R2/R3: OR exposes both held operands after the beats
                check("R2 R3 held operands", int'(bus_out), a | b);
            end
        end

        // R9: bus traffic without strobes leaves the result alone
        load_word(1'b0, 5);
        load_word(1'b1, 3);
        op_code = 3'b000;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            bus_in = (k * 7 + 9) & MASK;
        end
        @(negedge clk);
        #1;
        check("R9 isolated result", int'(bus_out), 8);

        // R2: loading left only leaves right untouched
        load_word(1'b0, 12);
        op_code = 3'b001;
        #1;
        check("R2 left only", int'(bus_out), 9);
        check("R5 no borrow", int'(carry), 1);

        // R1: reset mid-run clears both operands again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        op_code = 3'b011;
        #1;
        check("R1 re-reset", int'(bus_out), 0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule